// File: doc/BRIEF.md
# Abstract Command Sequencer with Sticky Error Latch

This block sits between a debugger's 32-bit register port and the core that executes abstract commands. The debugger writes a command word. The sequencer marks itself busy, hands the word to the executor with a one-cycle start pulse, and stays busy until the executor reports completion. It also holds a bank of data words, a bank of program-buffer words, and an auto-execute mask. Touching a masked word re-issues the stored command, so a debugger can stream data through a repeated command without rewriting it.

A three-bit error field guards the whole sequence. Any access that collides with a running command sets it to the busy code. An executor failure stores the executor's code. Once the field is non-zero, no command is launched, explicit or automatic, until the debugger writes ones to the field's bits. The meaning of command types and the execution itself belong to the executor.

Top module: `acs_seq`

## Requirements
- R1: A command write with busy clear and a zero error field raises `cmd_start` for exactly the cycle after the write edge, with `cmd_word` equal to the written word (type in bits [31:24], argument in bits [23:0]). Busy (status bit 12) is set from that edge and clears on the edge where `exec_done` is sampled high.
- R2: A write to the command (0x11), status (0x10) or auto-execute (0x12) address while busy sets a zero error field to 1 (busy). The stored command and auto-execute values keep their contents.
- R3: A read or write of any data or program-buffer word while busy sets a zero error field to 1. A write made while busy leaves the stored word unchanged. A read made while busy still returns the stored word.
- R4: While the error field is non-zero, a command write neither starts a command nor changes the stored command.
- R5: The error field (status bits [10:8]) changes from a non-zero value only on a status write made while idle, and only in the bits written as 1. Writing 0 leaves it as it is.
- R6: On completion, a non-zero executor code (2 not supported, 3 exception, 4 wrong halt/run state, 7 other) is stored only if the error field is zero. Otherwise the earlier code is kept.
- R7: A read of the command address returns the last accepted command word. The reset value is 0.
- R8: The auto-execute register keeps data-word enables in bits [11:0] and program-buffer enables in bits [31:16]. Bits for words that are not built read 0. With busy clear and a zero error field, a read or write of a data or program-buffer word whose enable is set re-issues the stored command exactly as in R1, and a write still stores the word. While the error field is non-zero, such an access starts nothing.
- R9: A status read returns the data-word count in bits [3:0], the program-buffer size in bits [28:24], busy in bit 12 and the error field in [10:8]. All other bits are 0. After reset the error field is 0 and busy is clear.
- R10: Data word i sits at address i and program-buffer word i at 0x20+i. Read data appears on `rsp_rdata` with `rsp_valid` the cycle after the request edge. Unmapped addresses, including words beyond the built counts, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 6 | Register address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| cmd_start | output | 1 | One-cycle command launch pulse |
| cmd_word | output | 32 | Stored command word toward the executor |
| exec_done | input | 1 | Executor completion, honoured while busy |
| exec_err | input | 3 | Executor result code, sampled with `exec_done` |

## Verification
Read data is checked on the cycle after the request edge. Each read pushes its expected word into a queue before it is driven, and a monitor pops and compares the entry when `rsp_valid` rises. The start pulse and busy both appear on the edge that samples the command write, so a status read issued in the very next cycle must already show busy. A stub executor answers six cycles after each start. The bench leaves a twelve-cycle gap before it checks start counts, the last launched word, or an error code that an executor result or a collision has latched.

// File: rtl/acs_pkg.sv
package acs_pkg;
    localparam logic [2:0] ERR_NONE  = 3'd0;
    localparam logic [2:0] ERR_BUSY  = 3'd1;
    localparam logic [2:0] ERR_NOSUP = 3'd2;
    localparam logic [2:0] ERR_EXC   = 3'd3;
    localparam logic [2:0] ERR_STATE = 3'd4;
    localparam logic [2:0] ERR_OTHER = 3'd7;

    localparam logic [5:0] ADR_STATUS = 6'h10;
    localparam logic [5:0] ADR_CMD    = 6'h11;
    localparam logic [5:0] ADR_AUTO   = 6'h12;

    localparam int BUSY_BIT = 12;
    localparam int ERR_LSB  = 8;
    localparam int PBUF_LSB = 16;

    typedef struct packed {
        logic [7:0]  kind;
        logic [23:0] arg;
    } acs_cmd_t;

    typedef struct packed {
        logic        busy;
        logic [2:0]  err;
        acs_cmd_t    cmd;
        logic [31:0] auto;
        logic        start;
    } acs_state_t;

    typedef struct packed {
        logic        valid;
        logic [31:0] data;
    } acs_rsp_t;
endpackage

// File: rtl/acs_word_bank.sv
module acs_word_bank #(
    parameter int N     = 12,
    parameter int W     = 32,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_data
);
    logic [W-1:0] words [N];

    for (genvar i = 0; i < N; i++) begin : g_word
        logic [W-1:0] word_d, word_q;

        always_comb begin
            word_d = word_q;
            if (wr_en && wr_idx == IDX_W'(i)) word_d = wr_data;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) word_q <= '0;
            else        word_q <= word_d;
        end

        assign words[i] = word_q;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N; i++) begin
            if (rd_idx == IDX_W'(i)) rd_data = words[i];
        end
    end
endmodule

// File: rtl/acs_ctrl.sv
module acs_ctrl
    import acs_pkg::*;
#(
    parameter int DATA_CNT = 12,
    parameter int PBUF_CNT = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic        stat_wr,
    input  logic        auto_wr,
    input  logic        word_acc,
    input  logic        auto_hit,
    input  logic [31:0] wdata,
    input  logic        exec_done,
    input  logic [2:0]  exec_err,
    output logic        busy,
    output logic [2:0]  err,
    output logic [31:0] cmd,
    output logic [31:0] auto_mask,
    output logic        start
);
    localparam logic [31:0] DATA_MASK = 32'((64'd1 << DATA_CNT) - 64'd1);
    localparam logic [31:0] PBUF_MASK = 32'(((64'd1 << PBUF_CNT) - 64'd1) << PBUF_LSB);
    localparam logic [31:0] AUTO_MASK = DATA_MASK | PBUF_MASK;

    acs_state_t s_d, s_q;
    logic collide, launch;

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        collide   = s_q.busy && (cmd_wr || stat_wr || auto_wr || word_acc);
        launch    = !s_q.busy && (s_q.err == ERR_NONE) &&
                    (cmd_wr || (word_acc && auto_hit));

        if (s_q.busy && exec_done) begin
            s_d.busy = 1'b0;
            if (s_q.err == ERR_NONE && exec_err != ERR_NONE) s_d.err = exec_err;
        end
        if (collide && s_q.err == ERR_NONE) s_d.err = ERR_BUSY;
        if (!s_q.busy && stat_wr) s_d.err = s_q.err & ~wdata[ERR_LSB +: 3];
        if (!s_q.busy && auto_wr) s_d.auto = wdata & AUTO_MASK;
        if (launch) begin
            if (cmd_wr) s_d.cmd = acs_cmd_t'(wdata);
            s_d.busy  = 1'b1;
            s_d.start = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy      = s_q.busy;
    assign err       = s_q.err;
    assign cmd       = s_q.cmd;
    assign auto_mask = s_q.auto;
    assign start     = s_q.start;

    p_busy_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy && !exec_done |=> s_q.busy);

    p_start_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.start |-> ($past(s_q.err) == ERR_NONE) && !$past(s_q.busy));

    p_reg_collide_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr || stat_wr || auto_wr) && s_q.busy && s_q.err == ERR_NONE
        |=> s_q.err == ERR_BUSY);

    p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.err != ERR_NONE && !stat_wr |=> $stable(s_q.err));

    p_first_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy && exec_done && s_q.err != ERR_NONE |=> $stable(s_q.err));
endmodule

// File: rtl/acs_seq.sv
module acs_seq
    import acs_pkg::*;
#(
    parameter int DATA_CNT = 12,
    parameter int PBUF_CNT = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [5:0]  req_addr,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        cmd_start,
    output logic [31:0] cmd_word,
    input  logic        exec_done,
    input  logic [2:0]  exec_err
);
    localparam int IDX_W = 4;

    logic [IDX_W-1:0] idx;
    logic is_data, is_pbuf, word_acc, auto_hit;
    logic cmd_wr, stat_wr, auto_wr;
    logic busy;
    logic [2:0] err;
    logic [31:0] cmd_q, auto_q, data_rd, pbuf_rd, status;
    acs_rsp_t rsp_d, rsp_q;

    assign idx      = req_addr[IDX_W-1:0];
    assign is_data  = (req_addr[5:4] == 2'b00) && (int'(idx) < DATA_CNT);
    assign is_pbuf  = (req_addr[5:4] == 2'b10) && (int'(idx) < PBUF_CNT);
    assign word_acc = req_valid && (is_data || is_pbuf);
    assign cmd_wr   = req_valid && req_write && (req_addr == ADR_CMD);
    assign stat_wr  = req_valid && req_write && (req_addr == ADR_STATUS);
    assign auto_wr  = req_valid && req_write && (req_addr == ADR_AUTO);

    always_comb begin
        auto_hit = 1'b0;
        if (is_data)      auto_hit = auto_q[5'(idx)];
        else if (is_pbuf) auto_hit = auto_q[5'(PBUF_LSB) + 5'(idx)];
    end

    acs_word_bank #(.N(DATA_CNT), .W(32), .IDX_W(IDX_W)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (req_valid && req_write && is_data && !busy),
        .wr_idx  (idx),
        .wr_data (req_wdata),
        .rd_idx  (idx),
        .rd_data (data_rd)
    );

    acs_word_bank #(.N(PBUF_CNT), .W(32), .IDX_W(IDX_W)) u_pbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (req_valid && req_write && is_pbuf && !busy),
        .wr_idx  (idx),
        .wr_data (req_wdata),
        .rd_idx  (idx),
        .rd_data (pbuf_rd)
    );

    acs_ctrl #(.DATA_CNT(DATA_CNT), .PBUF_CNT(PBUF_CNT)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .stat_wr   (stat_wr),
        .auto_wr   (auto_wr),
        .word_acc  (word_acc),
        .auto_hit  (auto_hit),
        .wdata     (req_wdata),
        .exec_done (exec_done),
        .exec_err  (exec_err),
        .busy      (busy),
        .err       (err),
        .cmd       (cmd_q),
        .auto_mask (auto_q),
        .start     (cmd_start)
    );

    assign status = {3'b0, 5'(PBUF_CNT), 11'b0, busy, 1'b0, err, 4'b0, 4'(DATA_CNT)};

    always_comb begin
        rsp_d.valid = req_valid && !req_write;
        rsp_d.data  = '0;
        if (rsp_d.valid) begin
            if (is_data)                      rsp_d.data = data_rd;
            else if (is_pbuf)                 rsp_d.data = pbuf_rd;
            else if (req_addr == ADR_STATUS)  rsp_d.data = status;
            else if (req_addr == ADR_CMD)     rsp_d.data = cmd_q;
            else if (req_addr == ADR_AUTO)    rsp_d.data = auto_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_rdata = rsp_q.data;
    assign cmd_word  = cmd_q;

    p_word_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
        word_acc && busy |=> err != ERR_NONE);

    p_auto_launch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        word_acc && auto_hit && !busy && err == ERR_NONE |=> cmd_start);
endmodule

// File: tb/test_acs_seq.sv
module test_acs_seq;
    localparam logic [5:0] A_STAT = 6'h10;
    localparam logic [5:0] A_CMD  = 6'h11;
    localparam logic [5:0] A_AUTO = 6'h12;
    localparam int LAT = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [5:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, cmd_start;
    logic [31:0] rsp_rdata, cmd_word;
    logic        exec_done = 1'b0;
    logic [2:0]  exec_err = '0;

    logic [2:0]  stub_err = '0;
    int          starts = 0;
    logic [31:0] last_word = '0;
    int          n_cmp = 0, n_bad = 0;
    bit          ended = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;

    acs_seq i_acs_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .cmd_start(cmd_start), .cmd_word(cmd_word),
        .exec_done(exec_done), .exec_err(exec_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] st(input bit b, input logic [2:0] e);
        return 32'h1000_000C | (32'(b) << 12) | (32'(e) << 8);
    endfunction

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
        item_t it;
        it.exp = exp; it.tag = tag;
        sb.push_back(it);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle();
        repeat (12) @(negedge clk);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rsp_valid) begin
                if (sb.size() == 0) chk("R10 unexpected response", rsp_rdata, 32'hx);
                else begin
                    item_t it;
                    it = sb.pop_front();
                    chk(it.tag, rsp_rdata, it.exp);
                end
            end
        end
    end

    // stub executor
    initial begin
        forever begin
            @(negedge clk);
            if (cmd_start) begin
                starts++;
                last_word = cmd_word;
                repeat (LAT - 1) @(negedge clk);
                exec_done = 1'b1; exec_err = stub_err;
                @(negedge clk);
                exec_done = 1'b0; exec_err = '0;
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 / R7 / R8 reset state
        rd(A_STAT, st(0, 0), "R9 reset status");
        rd(A_CMD, 32'h0, "R7 reset command");
        rd(A_AUTO, 32'h0, "R8 reset auto");
        chk("R1 no start after reset", 32'(starts), 32'd0);

        // R1 basic launch
        wr(6'h00, 32'h11);
        wr(A_CMD, 32'h01AB_CDEF);
        rd(A_STAT, st(1, 0), "R1 busy next cycle");
        idle();
        chk("R1 one start", 32'(starts), 32'd1);
        chk("R1 command word", last_word, 32'h01AB_CDEF);
        rd(A_STAT, st(0, 0), "R1 idle after done");
        rd(A_CMD, 32'h01AB_CDEF, "R7 command readback");

        // R2 command write while busy
        wr(A_CMD, 32'h0200_0001);
        wr(A_CMD, 32'h0300_0002);
        idle();
        rd(A_STAT, st(0, 1), "R2 busy error");
        rd(A_CMD, 32'h0200_0001, "R2 command kept");
        chk("R2 start count", 32'(starts), 32'd2);

        // R4 command ignored under error
        wr(A_CMD, 32'h0400_0003);
        idle();
        chk("R4 no start with error", 32'(starts), 32'd2);
        rd(A_CMD, 32'h0200_0001, "R4 command unchanged");

        // R5 clear rules
        wr(A_STAT, 32'h0);
        rd(A_STAT, st(0, 1), "R5 zero write keeps error");
        wr(A_STAT, 32'h0000_0100);
        rd(A_STAT, st(0, 0), "R5 write one clears");

        // R3 data write while busy
        wr(6'h00, 32'hAAAA);
        wr(A_CMD, 32'h0500_0000);
        wr(6'h00, 32'hBBBB);
        idle();
        rd(6'h00, 32'hAAAA, "R3 data unchanged");
        rd(A_STAT, st(0, 1), "R3 write collision error");
        wr(A_STAT, 32'h0000_0700);

        // R3 program buffer read while busy
        wr(6'h25, 32'h55);
        wr(A_CMD, 32'h0500_0001);
        rd(6'h25, 32'h55, "R3 read while busy returns word");
        idle();
        rd(A_STAT, st(0, 1), "R3 read collision error");
        wr(A_STAT, 32'h0000_0700);

        // R2 auto and status writes while busy
        wr(A_CMD, 32'h0500_0002);
        wr(A_AUTO, 32'hFFFF_FFFF);
        idle();
        rd(A_AUTO, 32'h0, "R2 auto kept");
        rd(A_STAT, st(0, 1), "R2 auto collision error");
        wr(A_STAT, 32'h0000_0700);
        wr(A_CMD, 32'h0500_0003);
        wr(A_STAT, 32'h0000_0700);
        idle();
        rd(A_STAT, st(0, 1), "R2 status write collision");
        wr(A_STAT, 32'h0000_0700);
        chk("R2 starts so far", 32'(starts), 32'd6);

        // R6 executor error latch
        stub_err = 3'd3;
        wr(A_CMD, 32'h0600_0000);
        idle();
        rd(A_STAT, st(0, 3), "R6 exception latched");
        wr(A_STAT, 32'h0000_0700);
        stub_err = 3'd2;
        wr(A_CMD, 32'h0700_0000);
        wr(6'h01, 32'h5);
        idle();
        rd(A_STAT, st(0, 1), "R6 first error wins");
        wr(A_STAT, 32'h0000_0700);
        stub_err = 3'd0;
        chk("R6 starts", 32'(starts), 32'd8);

        // R8 auto-execute
        wr(A_AUTO, 32'hFFFF_FFFF);
        rd(A_AUTO, 32'hFFFF_0FFF, "R8 implemented bits");
        wr(A_AUTO, 32'h0002_0004);
        wr(A_CMD, 32'h0800_0008);
        idle();
        wr(6'h02, 32'h22);
        idle();
        chk("R8 data write retriggers", 32'(starts), 32'd10);
        chk("R8 retrigger word", last_word, 32'h0800_0008);
        rd(6'h02, 32'h22, "R8 data stored");
        idle();
        chk("R8 data read retriggers", 32'(starts), 32'd11);
        rd(6'h21, 32'h0, "R8 pbuf read");
        idle();
        chk("R8 pbuf read retriggers", 32'(starts), 32'd12);
        rd(6'h03, 32'h0, "R8 unmasked word");
        idle();
        chk("R8 unmasked no start", 32'(starts), 32'd12);
        wr(6'h21, 32'h1);
        wr(A_CMD, 32'h0900_0000);
        idle();
        wr(6'h02, 32'h33);
        idle();
        chk("R8 no retrigger under error", 32'(starts), 32'd13);
        rd(6'h02, 32'h33, "R8 write stored under error");
        idle();
        chk("R8 read no retrigger under error", 32'(starts), 32'd13);
        wr(A_STAT, 32'h0000_0700);
        wr(A_AUTO, 32'h0);

        // R10 address map
        wr(6'h2F, 32'hDEAD_BEEF);
        rd(6'h2F, 32'hDEAD_BEEF, "R10 last pbuf word");
        rd(6'h3F, 32'h0, "R10 unmapped high");
        rd(6'h0C, 32'h0, "R10 beyond data count");
        rd(6'h13, 32'h0, "R10 unmapped control");
        idle();
        chk("R10 scoreboard drained", 32'(sb.size()), 32'd0);

        if (!ended) begin
            ended = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule